// File: doc/BRIEF.md
# DMA Global Enable and Abort Gate

This block holds the global operation register of a multi-channel DMA controller and decides, channel by channel, whether transfers may proceed. The register carries a master enable and a flag that records a non-maskable interrupt. The block combines these with each channel's own enable bit, its transfer-end flag and a shared address-error flag, and gives every channel a permit signal.

When the gate closes while a channel is in the middle of a transfer unit, the channel is not cut off at once. Its permit stays high and a stop request is raised until the channel reports that the unit is done; the permit then drops. Clearing the master enable also sends a one-cycle terminate pulse to every channel that was active. The interrupt flag is sticky. Software clears it by reading it as 1 and then writing 0 to it; writing 1 does nothing.

Top module: `dma_gate_ctl`

## Requirements
- R1: After the flags have been stable for two clock edges, `ch_permit[i]` is 1 exactly when master enable is 1, `ch_en[i]` is 1, `ch_te[i]` is 0, the interrupt flag is 0 and `addr_err` is 0. A channel with `ch_busy[i]` at 0 loses its permit on the edge after the gate closes.
- R2: After reset, `reg_rdata` is 0 and `ch_permit`, `ch_stop_req` and `ch_term` are all 0.
- R3: A cycle with `nmi_in` high sets the interrupt flag (`reg_rdata` bit 1), even when no channel is enabled. While the flag is 1, every permit is 0.
- R4: If the gate closes while `ch_busy[i]` is 1, `ch_permit[i]` and `ch_stop_req[i]` stay 1 until `ch_unit_done[i]` is seen. Both drop on the edge that samples it.
- R5: A write with bit 1 at 0 clears the interrupt flag only after a read (`reg_rd`) has returned the flag as 1. A write of 0 with no such read, and any write of 1, leave the flag set. A write of 1 does not use up the arming read.
- R6: If the flag is set again after the arming read, a new read is needed before a write of 0 can clear it.
- R7: When `nmi_in` and a clearing write fall in the same cycle, the flag stays 1.
- R8: A write that changes master enable (`reg_rdata` bit 0) from 1 to 0 gives a one-cycle `ch_term[i]` pulse, on the edge that takes the write, for every channel whose permit was high. Busy channels then drain as in R4.
- R9: Master enable is written and read at bit 0 and the interrupt flag is read at bit 1. All other bits of `reg_rdata` read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_rd | input | 1 | Register read strobe; arms the flag clear when the flag reads 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data (bit 0 enable, bit 1 flag clear) |
| reg_rdata | output | REG_W | Register read value |
| nmi_in | input | 1 | Non-maskable interrupt event, sampled each cycle |
| addr_err | input | 1 | Global address-error flag |
| ch_en | input | NCH | Per-channel enable bits |
| ch_te | input | NCH | Per-channel transfer-end flags |
| ch_busy | input | NCH | Channel is inside a transfer unit |
| ch_unit_done | input | NCH | Channel finished its current unit |
| ch_permit | output | NCH | Channel may transfer |
| ch_stop_req | output | NCH | Channel must stop at the end of its unit |
| ch_term | output | NCH | One-cycle terminate pulse from clearing master enable |

## Verification
The hardest case to reach is a channel that is held in its drain state by an unfinished transfer unit. To get there, the channel must first hold a permit with `ch_busy` high, and then an interrupt or a clearing write must close the gate while `ch_unit_done` is kept low for several cycles. The bench reaches this by building the permits up first, then injecting the interrupt or the enable-clearing write. It checks permit, stop request and terminate pulse on each cycle before it releases the unit-done handshake. The arming sequence of the flag clear is reached in a similar way, by placing reads, repeated interrupts and same-cycle interrupt-plus-write in a fixed order.

// File: rtl/dma_gate_pkg.sv
// Shared constants and types for the DMA global gate.
// Assumes a single register with the enable at bit 0 and the flag at bit 1.
package dma_gate_pkg;
    localparam int DME_BIT  = 0;
    localparam int NMIF_BIT = 1;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } chan_state_e;
endpackage

// File: rtl/dma_gate_regs.sv
// Global operation register: master enable and sticky interrupt flag.
// The flag clears only on a write of 0 after a read returned it as 1.
// Assumes REG_W >= 2 and that reg_rd/reg_wr are single-cycle strobes.
module dma_gate_regs
    import dma_gate_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             nmi_in,
    output logic             dme,
    output logic             nmif,
    output logic             kill,
    output logic [REG_W-1:0] reg_rdata
);
    localparam logic [REG_W-1:0] DME_MASK  = REG_W'(1) << DME_BIT;
    localparam logic [REG_W-1:0] NMIF_MASK = REG_W'(1) << NMIF_BIT;

    logic dme_q;
    logic nmif_q;
    logic arm_q;
    logic wr_dme;
    logic wr_nmif_zero;

    // Decode the two implemented fields; all other write bits are dropped.
    always_comb begin
        wr_dme       = |(reg_wdata & DME_MASK);
        wr_nmif_zero = ~|(reg_wdata & NMIF_MASK);
    end

    // Master enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      dme_q <= 1'b0;
        else if (reg_wr) dme_q <= wr_dme;
    end

    // Interrupt flag with its read-arming bit; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmif_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (nmi_in) begin
            nmif_q <= 1'b1;
            arm_q  <= 1'b0;
        end else begin
            if (reg_rd && nmif_q)
                arm_q <= 1'b1;
            if (reg_wr && wr_nmif_zero && arm_q) begin
                nmif_q <= 1'b0;
                arm_q  <= 1'b0;
            end
        end
    end

    // Read view and the enable-fall event used for termination.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[DME_BIT]  = dme_q;
        reg_rdata[NMIF_BIT] = nmif_q;
        kill                = reg_wr & ~wr_dme & dme_q;
        dme                 = dme_q;
        nmif                = nmif_q;
    end
endmodule

// File: rtl/dma_gate_chan.sv
// Per-channel gate: registers the permit decision and drains a unit in flight.
// Assumes ch_unit_done is only raised while the channel is busy.
module dma_gate_chan
    import dma_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dme,
    input  logic nmif,
    input  logic addr_err,
    input  logic en,
    input  logic te,
    input  logic busy,
    input  logic unit_done,
    input  logic kill,
    output logic permit,
    output logic stop_req,
    output logic term
);
    chan_state_e state_q;
    chan_state_e state_d;
    logic        gate_ok;

    // Combined permission condition and next-state choice.
    always_comb begin
        gate_ok = dme & en & ~te & ~nmif & ~addr_err;
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (gate_ok) state_d = CH_RUN;
            CH_RUN:   if (!gate_ok) state_d = (busy && !unit_done) ? CH_DRAIN : CH_IDLE;
            CH_DRAIN: if (unit_done) state_d = CH_IDLE;
            default:  state_d = CH_IDLE;
        endcase
    end

    // Channel state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Terminate pulse for an active channel when master enable is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) term <= 1'b0;
        else        term <= kill & (state_q != CH_IDLE);
    end

    // Outputs decoded from state.
    always_comb begin
        permit   = (state_q != CH_IDLE);
        stop_req = (state_q == CH_DRAIN);
    end
endmodule

// File: rtl/dma_gate_ctl.sv
// Top of the DMA global gate: one operation register plus NCH channel gates.
// Assumes channel enable, transfer-end and address-error inputs are synchronous.
module dma_gate_ctl
    import dma_gate_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             nmi_in,
    input  logic             addr_err,
    input  logic [NCH-1:0]   ch_en,
    input  logic [NCH-1:0]   ch_te,
    input  logic [NCH-1:0]   ch_busy,
    input  logic [NCH-1:0]   ch_unit_done,
    output logic [NCH-1:0]   ch_permit,
    output logic [NCH-1:0]   ch_stop_req,
    output logic [NCH-1:0]   ch_term
);
    logic dme;
    logic nmif;
    logic kill;

    dma_gate_regs #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .nmi_in    (nmi_in),
        .dme       (dme),
        .nmif      (nmif),
        .kill      (kill),
        .reg_rdata (reg_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma_gate_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .dme       (dme),
            .nmif      (nmif),
            .addr_err  (addr_err),
            .en        (ch_en[i]),
            .te        (ch_te[i]),
            .busy      (ch_busy[i]),
            .unit_done (ch_unit_done[i]),
            .kill      (kill),
            .permit    (ch_permit[i]),
            .stop_req  (ch_stop_req[i]),
            .term      (ch_term[i])
        );
    end
endmodule

// File: rtl/dma_gate_chk.sv
// Checker for the DMA global gate, bound to the top by the statement below.
// Assumes the bit layout of the operation register from the package.
module dma_gate_chk
    import dma_gate_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             wr_flag_bit,
    input logic [REG_W-1:0] reg_rdata,
    input logic             nmi_in,
    input logic             addr_err,
    input logic [NCH-1:0]   ch_en,
    input logic [NCH-1:0]   ch_te,
    input logic [NCH-1:0]   ch_permit,
    input logic [NCH-1:0]   ch_stop_req,
    input logic [NCH-1:0]   ch_term
);
    logic dme_v;
    logic nmif_v;
    assign dme_v  = reg_rdata[DME_BIT];
    assign nmif_v = reg_rdata[NMIF_BIT];

    // R7
    nmi_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_in |=> nmif_v);

    // R5
    flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmif_v) |-> $past(reg_wr && !wr_flag_bit && !nmi_in));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:2] == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R1
        permit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_permit[i]) |-> $past(dme_v && ch_en[i] && !ch_te[i] && !nmif_v && !addr_err));

        // R4
        stop_holds_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_stop_req[i] |-> ch_permit[i]);

        // R8
        term_on_enable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_term[i] |-> ($past(dme_v) && !dme_v && $past(ch_permit[i])));

        // R8
        term_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_term[i] |=> !ch_term[i]);
    end
endmodule

bind dma_gate_ctl dma_gate_chk #(.NCH(NCH), .REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .wr_flag_bit (reg_wdata[1]),
    .reg_rdata   (reg_rdata),
    .nmi_in      (nmi_in),
    .addr_err    (addr_err),
    .ch_en       (ch_en),
    .ch_te       (ch_te),
    .ch_permit   (ch_permit),
    .ch_stop_req (ch_stop_req),
    .ch_term     (ch_term)
);

// File: tb/dma_gate_ctl_tb.sv
`timescale 1ns/1ps
module dma_gate_ctl_tb;
    localparam int NCH   = 6;
    localparam int REG_W = 16;
    localparam int NVEC  = 8;
    // Vector: {dme, en[5:0], te[5:0], ae, expected permit[5:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 6'h3F, 6'h00, 1'b0, 6'h3F},
        {1'b1, 6'h3F, 6'h05, 1'b0, 6'h3A},
        {1'b0, 6'h3F, 6'h00, 1'b0, 6'h00},
        {1'b1, 6'h12, 6'h00, 1'b0, 6'h12},
        {1'b1, 6'h3F, 6'h00, 1'b1, 6'h00},
        {1'b1, 6'h2A, 6'h08, 1'b0, 6'h22},
        {1'b1, 6'h00, 6'h00, 1'b0, 6'h00},
        {1'b1, 6'h3F, 6'h3F, 1'b0, 6'h00}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_rd = 1'b0;
    logic             reg_wr = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             nmi_in = 1'b0;
    logic             addr_err = 1'b0;
    logic [NCH-1:0]   ch_en = '0;
    logic [NCH-1:0]   ch_te = '0;
    logic [NCH-1:0]   ch_busy = '0;
    logic [NCH-1:0]   ch_unit_done = '0;
    logic [NCH-1:0]   ch_permit;
    logic [NCH-1:0]   ch_stop_req;
    logic [NCH-1:0]   ch_term;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    dma_gate_ctl #(.NCH(NCH), .REG_W(REG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
        .addr_err(addr_err), .ch_en(ch_en), .ch_te(ch_te), .ch_busy(ch_busy),
        .ch_unit_done(ch_unit_done), .ch_permit(ch_permit),
        .ch_stop_req(ch_stop_req), .ch_term(ch_term)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [REG_W-1:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic read_reg();
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk); nmi_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait_cyc(3);
        // R2: reset state
        check("R2 rdata", 32'(reg_rdata), 0);
        check("R2 permit", 32'(ch_permit), 0);
        check("R2 stop/term", 32'({ch_stop_req, ch_term}), 0);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R2 permit after release", 32'(ch_permit), 0);

        // R9: only bits 0 and 1 exist; R5: a write of 1 to the flag is ignored
        write_reg(16'hFFFD);
        check("R9 reserved read 0", 32'(reg_rdata), 32'h1);
        write_reg(16'hFFFF);
        check("R5 write 1 no set", 32'(reg_rdata), 32'h1);

        // R3: flag set with no channel active, then blocks all channels
        pulse_nmi();
        check("R3 flag set idle", 32'(reg_rdata), 32'h3);
        ch_en = 6'h3F;
        wait_cyc(3);
        check("R3 all blocked", 32'(ch_permit), 0);

        // R5: clear sequence
        write_reg(16'h0001);
        check("R5 write0 without read", 32'(reg_rdata), 32'h3);
        read_reg();
        write_reg(16'h0003);
        check("R5 write1 after read", 32'(reg_rdata), 32'h3);
        write_reg(16'h0001);
        check("R5 cleared", 32'(reg_rdata), 32'h1);
        wait_cyc(3);
        check("R1 permits restored", 32'(ch_permit), 32'h3F);

        // R1: vector table
        for (int k = 0; k < NVEC; k++) begin
            write_reg({15'h0, VEC[k][19]});
            ch_en    = VEC[k][18:13];
            ch_te    = VEC[k][12:7];
            addr_err = VEC[k][6];
            wait_cyc(3);
            check($sformatf("R1 vector %0d", k), 32'(ch_permit), 32'(VEC[k][5:0]));
        end
        write_reg(16'h0001);
        ch_en = 6'h3F; ch_te = '0; addr_err = 1'b0;
        wait_cyc(3);

        // R6: set again after arming read needs a fresh read
        pulse_nmi();
        read_reg();
        pulse_nmi();
        write_reg(16'h0001);
        check("R6 stale arm", 32'(reg_rdata), 32'h3);
        read_reg();
        write_reg(16'h0001);
        check("R6 clear after new read", 32'(reg_rdata), 32'h1);

        // R7: same-cycle event and clearing write
        pulse_nmi();
        read_reg();
        @(negedge clk); nmi_in = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0001;
        @(negedge clk); nmi_in = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        check("R7 set wins", 32'(reg_rdata), 32'h3);
        read_reg();
        write_reg(16'h0001);
        check("R7 clear after", 32'(reg_rdata), 32'h1);
        wait_cyc(3);
        check("R1 permits before drain", 32'(ch_permit), 32'h3F);

        // R4: interrupt while channel 0 is inside a unit
        ch_busy = 6'h01;
        pulse_nmi();
        @(negedge clk);
        check("R4 drain permit", 32'(ch_permit), 32'h01);
        check("R4 drain stop", 32'(ch_stop_req), 32'h01);
        wait_cyc(3);
        check("R4 still draining", 32'({ch_permit, ch_stop_req}), 32'h041);
        @(negedge clk); ch_unit_done = 6'h01;
        @(negedge clk); ch_unit_done = '0; ch_busy = '0;
        check("R4 dropped after done", 32'({ch_permit, ch_stop_req}), 0);
        read_reg();
        write_reg(16'h0001);
        ch_en = 6'h0F;
        wait_cyc(3);
        check("R1 permits partial", 32'(ch_permit), 32'h0F);

        // R8: clear master enable with channels 0 and 1 busy
        ch_busy = 6'h03;
        write_reg(16'h0000);
        check("R8 term pulse", 32'(ch_term), 32'h0F);
        check("R8 enable read 0", 32'(reg_rdata), 0);
        @(negedge clk);
        check("R8 term one cycle", 32'(ch_term), 0);
        check("R8 busy drain", 32'({ch_permit, ch_stop_req}), 32'h0C3);
        @(negedge clk); ch_unit_done = 6'h03;
        @(negedge clk); ch_unit_done = '0; ch_busy = '0;
        check("R8 drained", 32'(ch_permit), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule